// File: doc/BRIEF.md
# Interrupt request and context-save unit

This unit gathers six interrupt sources (two timers, a serial port, a port wakeup and two external pins) into a request flag register. The flags are qualified by a per-source enable mask and by a global enable bit. When an enabled request is pending and the global enable is set, the unit accepts it. It redirects the program counter to a fixed vector, strobes a return-address push, lowers the global enable so that service cannot nest, and moves a 3-bit stack pointer down one level. A return strobe raises the enable again and moves the pointer back up.

The global enable and the stack pointer share one register, at address 0xDF by default. A second register holds the request flags. Software clears a flag by writing 0 to it. A one-level shadow buffer saves the accumulator and the flag register on a push command and hands them back on a pop command. Two status bits of the flag register are never saved: on a pop they keep their live values.

All pins are plain control and status strobes. No interface carries back-pressure. Each strobe acts in the cycle it is high, and each result is offered for exactly one cycle.

Top module: `irq_ctx_unit`

## Requirements
- R1: After reset all request flags are 0, the stack register reads 8'h07 (global enable 0, pointer 3'b111), and pc_load, stk_wrap and ctx_restore are low.
- R2: A high src_pulse bit sets the matching flag from the next cycle on. The flag register maps bit 0 to external pin 0, bit 1 to external pin 1, bit 2 to the wakeup source, bit 3 to the serial port, bit 4 to timer 0 and bit 5 to timer 1. Bits 7:6 read 0.
- R3: A write to the flag register loads bits 5:0. Writing 0 clears a flag. A source pulse in the same cycle wins over the clear.
- R4: The stack register holds the global enable in bit 7 and the pointer in bits 2:0. Both are read/write, and bits 6:3 read 0. Any other address reads 0.
- R5: While the global enable is 0, pc_load never rises.
- R6: When the global enable is 1 and some flag with its src_en bit set is pending, pc_load is high in the next cycle. In that cycle pc_vector equals 8 and irq_id gives the lowest-numbered enabled pending bit. Flags whose src_en bit is 0 never cause acceptance.
- R7: Acceptance clears the global enable, decrements the pointer and raises stk_push together with pc_load.
- R8: A reti strobe with no acceptance in the same cycle sets the global enable and increments the pointer.
- R9: stk_wrap pulses for one cycle when the pointer wraps, either from 0 to 7 on acceptance or from 7 to 0 on reti.
- R10: ctx_push stores acc_in and pflag_in. The cycle after a ctx_pop, ctx_restore is high, and acc_out and pflag_out give the stored values. The outputs hold until the next pop.
- R11: The buffer is one level deep, so a second push overwrites the first.
- R12: Flag-register bits 7 and 6 are the two status bits that are never saved. On a pop, pflag_out takes these bits from pflag_in in the pop cycle.
- R13: In a cycle with acceptance or reti, a write to the stack register is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| src_pulse | input | 6 | One-cycle request pulses per source |
| src_en | input | 6 | Per-source enable mask |
| reti | input | 1 | Return-from-interrupt strobe |
| pc_load | output | 1 | PC redirect strobe |
| pc_vector | output | 12 | Vector address, valid with pc_load |
| stk_push | output | 1 | Return-address push strobe |
| irq_id | output | 3 | Accepted source index, valid with pc_load |
| stk_wrap | output | 1 | Pointer wrap pulse |
| ctx_push | input | 1 | Save context strobe |
| ctx_pop | input | 1 | Restore context strobe |
| acc_in | input | 8 | Live accumulator |
| pflag_in | input | 8 | Live flag register |
| ctx_restore | output | 1 | Restored context valid |
| acc_out | output | 8 | Restored accumulator |
| pflag_out | output | 8 | Restored flag register |

## Verification
Register read data is combinational. It shows a write or a pulse one cycle later, after a single flop stage. pc_load, stk_push, irq_id and stk_wrap appear in the cycle after the pending and enable conditions held. ctx_restore and its data appear in the cycle after ctx_pop. The bench changes its inputs just after each rising edge and updates its model once per edge. It compares every output and the read data 1 ns after that edge, so each result is checked in the exact cycle it is due.

// File: rtl/irq_ctx_pkg.sv
package irq_ctx_pkg;
  localparam int NSRC  = 6;
  localparam int IDW   = $clog2(NSRC);
  localparam int DW    = 8;
  typedef logic [DW-1:0]   word_t;
  typedef logic [NSRC-1:0] src_vec_t;

  function automatic logic [IDW-1:0] lowest_set(input src_vec_t v);
    logic [IDW-1:0] idx;
    idx = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (v[i]) idx = IDW'(i);
    return idx;
  endfunction
endpackage

// File: rtl/irq_req_flags.sv
module irq_req_flags
  import irq_ctx_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  src_vec_t       wr_bits,
  input  src_vec_t       src_pulse,
  input  src_vec_t       src_en,
  output src_vec_t       flags,
  output logic           pending,
  output logic [IDW-1:0] first_id
);
  src_vec_t live;

  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            flags[i] <= 1'b0;
      else if (src_pulse[i]) flags[i] <= 1'b1;
      else if (wr_en)        flags[i] <= wr_bits[i];
    end
  end

  assign live     = flags & src_en;
  assign pending  = |live;
  assign first_id = lowest_set(live);

  a_r6_first_is_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> (flags[first_id] && src_en[first_id]));
  a_r2_pulse_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_pulse) |=> ((flags & $past(src_pulse)) == $past(src_pulse)));
  a_r3_clear_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_bits == '0 && src_pulse == '0) |=> (flags == '0));
endmodule

// File: rtl/irq_stack_ctl.sv
module irq_stack_ctl #(
  parameter int SP_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic            reti,
  input  logic            wr_en,
  input  logic            wr_gie,
  input  logic [SP_W-1:0] wr_sp,
  output logic            gie,
  output logic [SP_W-1:0] sp,
  output logic            wrap
);
  localparam logic [SP_W-1:0] SP_TOP = '1;
  localparam logic [SP_W-1:0] SP_BOT = '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie  <= 1'b0;
      sp   <= SP_TOP;
      wrap <= 1'b0;
    end else begin
      wrap <= 1'b0;
      if (take) begin
        gie  <= 1'b0;
        sp   <= sp - 1'b1;
        wrap <= (sp == SP_BOT);
      end else if (reti) begin
        gie  <= 1'b1;
        sp   <= sp + 1'b1;
        wrap <= (sp == SP_TOP);
      end else if (wr_en) begin
        gie <= wr_gie;
        sp  <= wr_sp;
      end
    end
  end

  a_r9_wrap_edges: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> (($past(sp) == SP_BOT && sp == SP_TOP) || ($past(sp) == SP_TOP && sp == SP_BOT)));
  a_r8_reti_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !take) |=> gie);
  a_r13_take_beats_write: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (!gie && sp == $past(sp) - 1'b1));
endmodule

// File: rtl/irq_shadow.sv
module irq_shadow #(
  parameter int          DW        = 8,
  parameter logic [DW-1:0] KEEP_MASK = 8'hC0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] acc_in,
  input  logic [DW-1:0] flg_in,
  output logic          restore,
  output logic [DW-1:0] acc_out,
  output logic [DW-1:0] flg_out
);
  logic [DW-1:0] acc_q, flg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      flg_q   <= '0;
      restore <= 1'b0;
      acc_out <= '0;
      flg_out <= '0;
    end else begin
      restore <= pop;
      if (pop) begin
        acc_out <= acc_q;
        flg_out <= (flg_q & ~KEEP_MASK) | (flg_in & KEEP_MASK);
      end
      if (push) begin
        acc_q <= acc_in;
        flg_q <= flg_in;
      end
    end
  end

  a_r12_live_bits: assert property (@(posedge clk) disable iff (!rst_n)
    restore |-> ((flg_out & KEEP_MASK) == ($past(flg_in) & KEEP_MASK)));
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pop |=> ($stable(acc_out) && $stable(flg_out)));
endmodule

// File: rtl/irq_ctx_unit.sv
module irq_ctx_unit
  import irq_ctx_pkg::*;
#(
  parameter int          PC_W      = 12,
  parameter int          SP_W      = 3,
  parameter logic [7:0]  FLAG_ADDR = 8'hC8,
  parameter logic [7:0]  STK_ADDR  = 8'hDF,
  parameter logic [PC_W-1:0] VECTOR = 12'd8,
  parameter logic [7:0]  KEEP_MASK = 8'hC0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [7:0]      reg_addr,
  input  logic            reg_we,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  input  logic [5:0]      src_pulse,
  input  logic [5:0]      src_en,
  input  logic            reti,
  output logic            pc_load,
  output logic [PC_W-1:0] pc_vector,
  output logic            stk_push,
  output logic [2:0]      irq_id,
  output logic            stk_wrap,
  input  logic            ctx_push,
  input  logic            ctx_pop,
  input  logic [7:0]      acc_in,
  input  logic [7:0]      pflag_in,
  output logic            ctx_restore,
  output logic [7:0]      acc_out,
  output logic [7:0]      pflag_out
);
  localparam int PAD_STK = DW - 1 - SP_W;

  src_vec_t        flags;
  logic            pending, take, gie_q;
  logic [IDW-1:0]  first_id;
  logic [SP_W-1:0] sp_q;
  logic            flag_wr, stk_wr;
  logic [PAD_STK-1:0] unused_wbits;

  assign flag_wr      = reg_we && (reg_addr == FLAG_ADDR);
  assign stk_wr       = reg_we && (reg_addr == STK_ADDR);
  assign unused_wbits = reg_wdata[DW-2:SP_W];
  assign take         = gie_q && pending;

  irq_req_flags u_flags (
    .clk(clk), .rst_n(rst_n), .wr_en(flag_wr), .wr_bits(reg_wdata[NSRC-1:0]),
    .src_pulse(src_pulse), .src_en(src_en), .flags(flags),
    .pending(pending), .first_id(first_id)
  );

  irq_stack_ctl #(.SP_W(SP_W)) u_stack (
    .clk(clk), .rst_n(rst_n), .take(take), .reti(reti), .wr_en(stk_wr),
    .wr_gie(reg_wdata[DW-1]), .wr_sp(reg_wdata[SP_W-1:0]),
    .gie(gie_q), .sp(sp_q), .wrap(stk_wrap)
  );

  irq_shadow #(.DW(DW), .KEEP_MASK(KEEP_MASK)) u_shadow (
    .clk(clk), .rst_n(rst_n), .push(ctx_push), .pop(ctx_pop),
    .acc_in(acc_in), .flg_in(pflag_in), .restore(ctx_restore),
    .acc_out(acc_out), .flg_out(pflag_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_load   <= 1'b0;
      pc_vector <= '0;
      irq_id    <= '0;
    end else begin
      pc_load   <= take;
      pc_vector <= take ? VECTOR : '0;
      irq_id    <= take ? first_id : '0;
    end
  end

  assign stk_push = pc_load;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == FLAG_ADDR)     reg_rdata = {{(DW-NSRC){1'b0}}, flags};
    else if (reg_addr == STK_ADDR) reg_rdata = {gie_q, {PAD_STK{1'b0}}, sp_q};
  end

  a_r5_gie_gate: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> $past(gie_q));
  a_r7_no_nesting: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> !gie_q);
  a_r6_vector: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> (pc_vector == VECTOR));
endmodule

// File: tb/tb_irq_ctx_unit.sv
module tb_irq_ctx_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] FA = 8'hC8, SA = 8'hDF, KEEP = 8'hC0;

  logic clk = 0, rst_n = 0;
  logic [7:0] reg_addr = 0, reg_wdata = 0, acc_in = 0, pflag_in = 0;
  logic reg_we = 0, reti = 0, ctx_push = 0, ctx_pop = 0;
  logic [5:0] src_pulse = 0, src_en = 0;
  logic [7:0] reg_rdata, acc_out, pflag_out;
  logic pc_load, stk_push, stk_wrap, ctx_restore;
  logic [11:0] pc_vector;
  logic [2:0] irq_id;

  int n_chk = 0, n_fail = 0;

  logic [5:0] m_fl;
  logic m_gie, e_load, e_wrap, e_rest;
  logic [2:0] m_sp, e_id;
  logic [7:0] m_sacc, m_sfl, m_acc, m_pfl;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_ctx_unit dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_pulse(src_pulse),
    .src_en(src_en), .reti(reti), .pc_load(pc_load), .pc_vector(pc_vector),
    .stk_push(stk_push), .irq_id(irq_id), .stk_wrap(stk_wrap),
    .ctx_push(ctx_push), .ctx_pop(ctx_pop), .acc_in(acc_in), .pflag_in(pflag_in),
    .ctx_restore(ctx_restore), .acc_out(acc_out), .pflag_out(pflag_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    if (a == FA) return {2'b00, m_fl};
    if (a == SA) return {m_gie, 4'b0000, m_sp};
    return 8'h00;
  endfunction

  function automatic logic [2:0] low_bit(input logic [5:0] v);
    logic [2:0] r = 0;
    for (int i = 5; i >= 0; i--) if (v[i]) r = 3'(i);
    return r;
  endfunction

  task automatic quiet();
    reg_we = 0; src_pulse = 0; reti = 0; ctx_push = 0; ctx_pop = 0;
  endtask

  task automatic step();
    logic take;
    logic [5:0] nfl;
    take   = m_gie && |(m_fl & src_en);
    e_load = take;
    e_id   = take ? low_bit(m_fl & src_en) : 3'd0;
    e_wrap = 0;
    nfl = (reg_we && reg_addr == FA) ? reg_wdata[5:0] : m_fl;
    nfl = nfl | src_pulse;
    e_rest = ctx_pop;
    if (ctx_pop) begin
      m_acc = m_sacc;
      m_pfl = (m_sfl & ~KEEP) | (pflag_in & KEEP);
    end
    if (ctx_push) begin m_sacc = acc_in; m_sfl = pflag_in; end
    if (take) begin e_wrap = (m_sp == 0); m_gie = 0; m_sp = m_sp - 1; end
    else if (reti) begin e_wrap = (m_sp == 7); m_gie = 1; m_sp = m_sp + 1; end
    else if (reg_we && reg_addr == SA) begin m_gie = reg_wdata[7]; m_sp = reg_wdata[2:0]; end
    m_fl = nfl;
    @(posedge clk); #1;
    chk("R6 pc_load", 32'(pc_load), 32'(e_load));
    chk("R6 irq_id", 32'(irq_id), 32'(e_id));
    chk("R6 vector", 32'(pc_vector), e_load ? 32'd8 : 32'd0);
    chk("R7 stk_push", 32'(stk_push), 32'(e_load));
    chk("R9 wrap", 32'(stk_wrap), 32'(e_wrap));
    chk("R10 restore", 32'(ctx_restore), 32'(e_rest));
    chk("R10 acc_out", 32'(acc_out), 32'(m_acc));
    chk("R12 pflag_out", 32'(pflag_out), 32'(m_pfl));
    chk(reg_addr == SA ? "R4 rdata" : "R2 rdata", 32'(reg_rdata), 32'(exp_rd(reg_addr)));
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [7:0] exp);
    reg_addr = a; #1;
    chk(req, 32'(reg_rdata), 32'(exp));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_fl = 0; m_gie = 0; m_sp = 7; m_sacc = 0; m_sfl = 0; m_acc = 0; m_pfl = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    rd("R1 stk reset", SA, 8'h07);
    rd("R1 flags reset", FA, 8'h00);
    chk("R1 pc_load", 32'(pc_load), 0);
    chk("R1 wrap/restore", 32'({stk_wrap, ctx_restore}), 0);
    rd("R4 other addr", 8'h10, 8'h00);

    // R5: requests pending with gie=0 never accepted
    src_en = 6'h3F; src_pulse = 6'h08; step(); quiet();
    repeat (3) begin step(); chk("R5 no accept gie0", 32'(pc_load), 0); end
    rd("R2 serial flag", FA, 8'h08);

    // R3: clear and pulse in same cycle, pulse wins
    reg_addr = FA; reg_we = 1; reg_wdata = 8'h00; src_pulse = 6'h02; step(); quiet();
    rd("R3 pulse beats clear", FA, 8'h02);
    reg_addr = FA; reg_we = 1; reg_wdata = 8'h00; step(); quiet();
    rd("R3 cleared", FA, 8'h00);

    // R6 masked flag, R9 wrap on take from sp=0
    src_en = 6'h00; src_pulse = 6'h30; step(); quiet();
    reg_addr = SA; reg_we = 1; reg_wdata = 8'h80; step(); quiet();
    step(); chk("R6 masked no accept", 32'(pc_load), 0);
    src_en = 6'h20; step();
    chk("R6 accept timer1", 32'({pc_load, irq_id}), 32'({1'b1, 3'd5}));
    chk("R9 wrap 0->7", 32'(stk_wrap), 1);
    rd("R7 gie cleared sp dec", SA, 8'h07);

    // R8 reti, R9 wrap 7->0
    reti = 1; step(); quiet();
    chk("R9 wrap 7->0", 32'(stk_wrap), 1);
    rd("R8 reti sets gie", SA, 8'h80);
    // R13: accept pending now; same-cycle write ignored
    reg_addr = SA; reg_we = 1; reg_wdata = 8'h85; step(); quiet();
    rd("R13 write ignored on take", SA, 8'h07);
    reg_addr = FA; reg_we = 1; reg_wdata = 8'h00; step(); quiet();

    // R10/R11/R12 shadow
    acc_in = 8'h11; pflag_in = 8'h05; ctx_push = 1; step(); quiet();
    acc_in = 8'h22; pflag_in = 8'h3A; ctx_push = 1; step(); quiet();
    pflag_in = 8'hC0; ctx_pop = 1; step(); quiet();
    chk("R11 second push overwrote", 32'(acc_out), 32'h22);
    chk("R12 kept live bits", 32'(pflag_out), 32'hFA);

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      src_pulse = (($urandom % 4) == 0) ? 6'($urandom) & 6'($urandom) : 6'h00;
      src_en    = 6'($urandom);
      reg_we    = (($urandom % 4) == 0);
      case ($urandom % 3)
        0: reg_addr = FA;
        1: reg_addr = SA;
        default: reg_addr = 8'($urandom);
      endcase
      reg_wdata = 8'($urandom);
      reti      = (($urandom % 6) == 0);
      ctx_push  = (($urandom % 4) == 0);
      ctx_pop   = (($urandom % 4) == 0);
      acc_in    = 8'($urandom);
      pflag_in  = 8'($urandom);
      step();
    end
    quiet();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule